// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes received Ethernet frames, delivered as a byte stream with start, end and error marks, and stores them in memory buffers that software describes through a ring of eight-byte descriptors. At the start of every frame it reads the next descriptor over a simple synchronous memory port. If software has marked that descriptor as free, the block writes the frame bytes into the descriptor's buffer and then writes the length and a completion status back into the descriptor. The status write-back returns ownership of the descriptor to software.

The ring has no length register. A flag inside a descriptor marks the last entry, and the index returns to the ring base after that entry. If the next descriptor is still owned by software when a frame arrives, the block raises a busy event. It then stays halted and drops frames until software issues a clear-halt command. A small register interface holds the ring base, the maximum buffer length, the busy event and the halt command.

Top module: `rxr_desc_ring`

## Requirements
- R1: Descriptor i sits at ring base + 8·i. Its first 32-bit word holds the status in bits 31:16 and the length in bits 15:0, and its second word holds the buffer byte address. Byte k of a word uses data bits [31-8k -: 8] and byte enable bit 3-k.
- R2: A frame is stored only into a descriptor whose status bit 15 (free) is 1. The write-back clears bit 15, sets bit 11 (last of frame) and keeps bit 13 (ring end) as it was read.
- R3: After a descriptor with status bit 13 set, the next descriptor used is index 0. Otherwise the next descriptor is the following index.
- R4: Frame byte k goes to buffer address + k, one masked byte write per byte. Every payload write comes before the status write-back. The written length is the number of bytes received, including the 4 check-sequence bytes.
- R5: An error mark on any byte of a frame sets status bit 1. The frame still uses up its descriptor and the index advances.
- R6: The maximum-length register (address 1, reset value 1536) limits storage. Bytes at offsets at or above the limit are not written, status bit 0 is set, and the written length equals the limit. A frame exactly at the limit is not truncated.
- R7: If the descriptor read at frame start has bit 15 clear, event bit 0 (busy) and the halt flag are both set. The frame is then dropped with no memory write, and the descriptor index does not change.
- R8: While halted, every arriving frame is consumed and dropped whole. The halt flag reads as bit 0 of address 3 and is cleared only by writing 1 to bit 0 of address 3.
- R9: Event bit 0 (address 2) is write-one-to-clear. Writing 0 leaves it unchanged, and clearing it does not clear the halt flag.
- R10: Writing the ring base (address 0, low 3 bits forced to zero) sets the descriptor index to 0.
- R11: After reset the ring base is 0, the event and halt flags are 0, the maximum length is 1536, rx_ready is low and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Frame byte present |
| rx_ready | output | 1 | Byte accepted on this edge when valid |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_err | input | 1 | Error mark on this byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
On every cycle the checker confirms the following:
- Memory writes are either single byte lanes or full status words.
- Every status write-back hands the descriptor back with the last-of-frame bit set.
- The descriptor index rewinds on a ring-end write-back or a base write, and otherwise steps by one.
- No memory access happens while halted, and a busy event never rises without the halt.

Only the bench scenarios can show the following:
- The stored payload bytes, the length values and the truncation boundary at the limit.
- The error bit on a consumed descriptor.
- Which descriptor each frame lands in across ring wraps.
- The full sequence of halt, drop, event clear and resume.

// File: rtl/rxr_pkg.sv
// Shared definitions for the receive descriptor ring engine: status bit
// positions inside the 16-bit descriptor status, register word indices
// and the engine state type.
package rxr_pkg;
    localparam int LEN_W    = 16;
    localparam int ST_FREE  = 15;
    localparam int ST_END   = 13;
    localparam int ST_LAST  = 11;
    localparam int ST_ERR   = 1;
    localparam int ST_TRUNC = 0;

    localparam logic [1:0] RA_BASE   = 2'd0;
    localparam logic [1:0] RA_MAXLEN = 2'd1;
    localparam logic [1:0] RA_EVENT  = 2'd2;
    localparam logic [1:0] RA_CMD    = 2'd3;

    typedef enum logic [2:0] {
        E_IDLE,
        E_CHK,
        E_PTR,
        E_RECV,
        E_WB,
        E_DROP
    } eng_state_t;
endpackage

// File: rtl/rxr_regs.sv
// Register block: ring base, maximum buffer length, busy event (W1C) and
// halt flag with its clear command. Assumes one register write per cycle.
// A busy report from the engine wins over a clear in the same cycle.
module rxr_regs
    import rxr_pkg::*;
#(
    parameter int RST_MAXLEN = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             busy_set,
    output logic [31:0]      reg_rdata,
    output logic [31:0]      ring_base,
    output logic [LEN_W-1:0] max_len,
    output logic             halted,
    output logic             evt_bsy,
    output logic             base_wr
);
    logic [31:0]      base_q;
    logic [LEN_W-1:0] maxlen_q;
    logic             bsy_q;
    logic             halt_q;

    assign base_wr = reg_wr && (reg_addr == RA_BASE);

    // Ring base register, kept aligned to a descriptor boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_wr) base_q <= {reg_wdata[31:3], 3'b000};
    end

    // Maximum buffer length register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  maxlen_q <= LEN_W'(RST_MAXLEN);
        else if (reg_wr && reg_addr == RA_MAXLEN)    maxlen_q <= reg_wdata[LEN_W-1:0];
    end

    // Busy event: set by the engine, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                                              bsy_q <= 1'b0;
        else if (busy_set)                                       bsy_q <= 1'b1;
        else if (reg_wr && reg_addr == RA_EVENT && reg_wdata[0]) bsy_q <= 1'b0;
    end

    // Halt flag: set by the engine, cleared only by the command write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                            halt_q <= 1'b0;
        else if (busy_set)                                     halt_q <= 1'b1;
        else if (reg_wr && reg_addr == RA_CMD && reg_wdata[0]) halt_q <= 1'b0;
    end

    // Combinational read mux.
    always_comb begin
        case (reg_addr)
            RA_BASE:   reg_rdata = base_q;
            RA_MAXLEN: reg_rdata = 32'(maxlen_q);
            RA_EVENT:  reg_rdata = {31'b0, bsy_q};
            default:   reg_rdata = {31'b0, halt_q};
        endcase
    end

    assign ring_base = base_q;
    assign max_len   = maxlen_q;
    assign halted    = halt_q;
    assign evt_bsy   = bsy_q;
endmodule

// File: rtl/rxr_ring_idx.sv
// Descriptor index keeper. It steps by one per completed descriptor and
// returns to zero after a ring-end descriptor or on a ring base write.
// The descriptor address is base + 8 * index.
module rxr_ring_idx #(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_wr,
    input  logic             advance,
    input  logic             wrap,
    input  logic [31:0]      ring_base,
    output logic [IDX_W-1:0] desc_idx,
    output logic [31:0]      desc_addr
);
    logic [IDX_W-1:0] idx_q;

    // Index update; a base write has priority over an advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (base_wr) idx_q <= '0;
        else if (advance) idx_q <= wrap ? '0 : idx_q + 1'b1;
    end

    assign desc_idx  = idx_q;
    assign desc_addr = ring_base + {{(29-IDX_W){1'b0}}, idx_q, 3'b000};
endmodule

// File: rtl/rxr_engine.sv
// Frame engine. At frame start it reads the current descriptor's status
// word and then its buffer pointer. It writes each accepted byte with a
// one-lane write, then writes status and length back. Assumptions:
// read data returns one cycle after the request, the port never stalls,
// and every frame begins with a start mark. The start byte waits
// (rx_ready low) during the two descriptor reads.
module rxr_engine
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [7:0]       rx_data,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_err,
    input  logic             halted,
    input  logic [LEN_W-1:0] max_len,
    input  logic [31:0]      desc_addr,
    output logic             busy_set,
    output logic             advance,
    output logic             wrap,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata
);
    eng_state_t       state, nxt;
    logic [31:0]      dsc_q;
    logic [31:0]      ptr_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] lim_q;
    logic             end_q;
    logic             err_q;
    logic             trunc_q;
    logic             take;
    logic             fits;
    logic [31:0]      byte_addr;
    logic [15:0]      st_word;
    logic [15:0]      len_word;

    assign rx_ready  = (state == E_RECV) || (state == E_DROP);
    assign take      = rx_valid && rx_ready;
    assign fits      = cnt_q < lim_q;
    assign byte_addr = ptr_q + 32'(cnt_q);
    assign wrap      = end_q;

    // Status word assembled for the write-back.
    always_comb begin
        st_word           = '0;
        st_word[ST_END]   = end_q;
        st_word[ST_LAST]  = 1'b1;
        st_word[ST_ERR]   = err_q;
        st_word[ST_TRUNC] = trunc_q;
        len_word          = trunc_q ? lim_q : cnt_q;
    end

    // Next state and memory port drive.
    always_comb begin
        nxt       = state;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        busy_set  = 1'b0;
        advance   = 1'b0;
        case (state)
            E_IDLE: begin
                if (rx_valid && rx_sof) begin
                    if (halted) begin
                        nxt = E_DROP;
                    end else begin
                        mem_req  = 1'b1;
                        mem_addr = desc_addr;
                        nxt      = E_CHK;
                    end
                end
            end
            E_CHK: begin
                if (mem_rdata[16+ST_FREE]) begin
                    mem_req  = 1'b1;
                    mem_addr = dsc_q + 32'd4;
                    nxt      = E_PTR;
                end else begin
                    busy_set = 1'b1;
                    nxt      = E_DROP;
                end
            end
            E_PTR: nxt = E_RECV;
            E_RECV: begin
                if (take) begin
                    if (fits) begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = {byte_addr[31:2], 2'b00};
                        mem_be    = 4'b1000 >> byte_addr[1:0];
                        mem_wdata = {4{rx_data}};
                    end
                    if (rx_eof) nxt = E_WB;
                end
            end
            E_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dsc_q;
                mem_be    = 4'hF;
                mem_wdata = {st_word, len_word};
                advance   = 1'b1;
                nxt       = E_IDLE;
            end
            E_DROP: if (take && rx_eof) nxt = E_IDLE;
            default: nxt = E_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= E_IDLE;
        else        state <= nxt;
    end

    // Per-frame descriptor fields captured during the fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsc_q <= '0;
            ptr_q <= '0;
            lim_q <= '0;
            end_q <= 1'b0;
        end else begin
            if (state == E_IDLE && rx_valid && rx_sof && !halted) dsc_q <= desc_addr;
            if (state == E_CHK) begin
                end_q <= mem_rdata[16+ST_END];
                lim_q <= max_len;
            end
            if (state == E_PTR) ptr_q <= mem_rdata;
        end
    end

    // Byte count and error accumulation for the frame in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            err_q   <= 1'b0;
            trunc_q <= 1'b0;
        end else if (state == E_PTR) begin
            cnt_q   <= '0;
            err_q   <= 1'b0;
            trunc_q <= 1'b0;
        end else if (state == E_RECV && take) begin
            if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            if (rx_err)      err_q <= 1'b1;
            if (!fits)       trunc_q <= 1'b1;
        end
    end
endmodule

// File: rtl/rxr_desc_ring.sv
// Top of the receive descriptor ring engine. It ties together the
// register block, the descriptor index keeper and the frame engine.
// Memory and registers use one clock with synchronous active-low reset.
module rxr_desc_ring
    import rxr_pkg::*;
#(
    parameter int IDX_W      = 12,
    parameter int RST_MAXLEN = 1536
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_err,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);
    logic [31:0]      ring_base;
    logic [LEN_W-1:0] max_len;
    logic             halted;
    logic             evt_bsy;
    logic             base_wr;
    logic             busy_set;
    logic             advance;
    logic             wrap;
    logic [IDX_W-1:0] desc_idx;
    logic [31:0]      desc_addr;

    rxr_regs #(.RST_MAXLEN(RST_MAXLEN)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy_set(busy_set), .reg_rdata(reg_rdata),
        .ring_base(ring_base), .max_len(max_len), .halted(halted),
        .evt_bsy(evt_bsy), .base_wr(base_wr)
    );

    rxr_ring_idx #(.IDX_W(IDX_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .advance(advance),
        .wrap(wrap), .ring_base(ring_base), .desc_idx(desc_idx),
        .desc_addr(desc_addr)
    );

    rxr_engine u_eng (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .halted(halted), .max_len(max_len), .desc_addr(desc_addr),
        .busy_set(busy_set), .advance(advance), .wrap(wrap),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );
endmodule

// File: rtl/rxr_desc_ring_chk.sv
// Property checker for the receive descriptor ring engine, bound into the
// top module. It observes the memory port, the register writes, the index
// and the halt/busy flags.
module rxr_desc_ring_chk #(
    parameter int IDX_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic [3:0]       mem_be,
    input logic [31:0]      mem_wdata,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [IDX_W-1:0] desc_idx,
    input logic             halted,
    input logic             evt_bsy
);
    logic stat_wr;
    logic base_w;
    assign stat_wr = mem_req && mem_we && (mem_be == 4'hF);
    assign base_w  = reg_wr && (reg_addr == 2'd0);

    // R4 / R1: writes are single byte lanes or a full status word.
    p_byte_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) == 1 || mem_be == 4'hF));

    // R2: write-back releases the descriptor and marks it last of frame.
    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |-> (!mem_wdata[31] && mem_wdata[27]));

    // R3: ring-end descriptor rewinds the index.
    p_wrap_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && mem_wdata[29] && !base_w) |=> (desc_idx == '0));

    // R3: ordinary descriptor steps the index by one.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !mem_wdata[29] && !base_w) |=> (desc_idx == $past(desc_idx) + 1'b1));

    // R8: no memory access while halted.
    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> !mem_req);

    // R7: busy event rises only together with the halt.
    p_bsy_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_bsy) |-> halted);

    // R10: base write rewinds the index.
    p_base_rewind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        base_w |=> (desc_idx == '0));
endmodule

bind rxr_desc_ring rxr_desc_ring_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .desc_idx(desc_idx), .halted(halted),
    .evt_bsy(evt_bsy)
);

// File: tb/rxr_desc_ring_bench.sv
module rxr_desc_ring_bench;
    localparam int PERIOD = 10;
    localparam int LIMIT  = 48;

    // Frame vectors: {error mark, length}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 16'd10}, {1'b1, 16'd5}, {1'b0, 16'd60},
        {1'b0, 16'd1},  {1'b0, 16'd48}, {1'b0, 16'd49}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:255];
    int n_chk = 0, n_bad = 0;
    int wr_cnt = 0, ooo_cnt = 0;
    bit stat_seen = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    rxr_desc_ring u_rxr_desc_ring (.*);

    // Memory model with one-cycle read latency; also tracks write order.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                wr_cnt <= wr_cnt + 1;
                if (mem_be == 4'hF) stat_seen <= 1'b1;
                else if (stat_seen) ooo_cnt <= ooo_cnt + 1;
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[9:2]];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic arm(input int dw, input bit last, input int bufa);
        mem[dw]     = {(last ? 16'hA000 : 16'h8000), 16'h0000};
        mem[dw + 1] = bufa;
        for (int j = 0; j < 16; j++) mem[bufa/4 + j] = 32'hEEEE_EEEE;
    endtask

    function automatic logic [7:0] get_byte(input int a);
        return mem[a/4][31 - 8*(a%4) -: 8];
    endfunction

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed + 7*k) & 255);
    endfunction

    task automatic send_frame(input int len, input bit err, input int seed);
        stat_seen = 1'b0;
        for (int k = 0; k < len; k++) begin
            rx_valid = 1'b1; rx_data = pat(seed, k);
            rx_sof = (k == 0); rx_eof = (k == len - 1); rx_err = err && (k == len - 1);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic int payload_bad(input int bufa, input int n, input int seed);
        int bad = 0;
        for (int k = 0; k < n; k++) if (get_byte(bufa + k) !== pat(seed, k)) bad++;
        return bad;
    endfunction

    // Watchdog
    initial begin
        #(PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int w0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // Reset state (R11)
        rd_reg(2'd0, d); chk("R11 base after reset", d, 32'h0);
        rd_reg(2'd1, d); chk("R11 maxlen after reset", d, 32'd1536);
        rd_reg(2'd2, d); chk("R11 event after reset", d, 32'h0);
        rd_reg(2'd3, d); chk("R11 halt after reset", d, 32'h0);
        chk("R11 ready in reset", {31'b0, rx_ready}, 32'h0);
        chk("R11 no mem access in reset", {31'b0, mem_req}, 32'h0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);

        // Three-entry ring at 0x000, buffers at 0x100 + 0x40*i
        for (int i = 0; i < 3; i++) arm(2*i, i == 2, 32'h100 + 32'h40*i);
        wr_reg(2'd1, LIMIT);

        // Table walk: frames land in descriptors 0,1,2,0,1,2 (R1, R2, R3, R4, R5, R6)
        for (int v = 0; v < 6; v++) begin
            int len, idx, stored, bufa, seed;
            bit err;
            logic [15:0] exp_st;
            len = int'(VEC[v][15:0]); err = VEC[v][16];
            idx = v % 3; bufa = 32'h100 + 32'h40*idx; seed = v*13 + 1;
            stored = (len > LIMIT) ? LIMIT : len;
            exp_st = 16'h0800 | ((idx == 2) ? 16'h2000 : 16'h0) | (err ? 16'h2 : 16'h0)
                     | ((len > LIMIT) ? 16'h1 : 16'h0);
            send_frame(len, err, seed);
            w0 = 2*idx;
            chk($sformatf("R2/R3/R5/R6 status vec%0d", v), {16'h0, mem[w0][31:16]}, {16'h0, exp_st});
            chk($sformatf("R4/R6 length vec%0d", v), {16'h0, mem[w0][15:0]}, stored);
            chk($sformatf("R1/R4 payload vec%0d", v), payload_bad(bufa, stored, seed), 0);
            if (len > LIMIT)
                chk($sformatf("R6 byte past limit vec%0d", v), {24'h0, get_byte(bufa + LIMIT)}, 32'hEE);
            arm(w0, idx == 2, bufa);
        end
        chk("R4 payload before status", ooo_cnt, 0);

        // Busy: index is 0 again; give descriptor 0 to software (R7)
        mem[0] = 32'h0000_0000;
        d = wr_cnt;
        send_frame(8, 1'b0, 77);
        chk("R7 no write on busy", wr_cnt, d);
        chk("R7 descriptor untouched", mem[0], 32'h0);
        rd_reg(2'd2, d); chk("R7 busy event set", d, 32'h1);
        rd_reg(2'd3, d); chk("R7 halt set", d, 32'h1);

        // Halted: dropped even with a free descriptor (R8)
        arm(0, 1'b0, 32'h100);
        d = wr_cnt;
        send_frame(9, 1'b0, 5);
        chk("R8 dropped while halted", wr_cnt, d);
        chk("R8 descriptor still free", mem[0], 32'h8000_0000);

        // Event write-one-to-clear (R9)
        wr_reg(2'd2, 32'h0); rd_reg(2'd2, d); chk("R9 write 0 keeps busy", d, 32'h1);
        wr_reg(2'd2, 32'h1); rd_reg(2'd2, d); chk("R9 write 1 clears busy", d, 32'h0);
        rd_reg(2'd3, d); chk("R9 halt kept after event clear", d, 32'h1);

        // Clear halt and resume in the same descriptor (R8, R7)
        wr_reg(2'd3, 32'h1); rd_reg(2'd3, d); chk("R8 halt cleared by command", d, 32'h0);
        send_frame(12, 1'b0, 33);
        chk("R7 resume in same descriptor status", {16'h0, mem[0][31:16]}, 32'h0800);
        chk("R7 resume length", {16'h0, mem[0][15:0]}, 32'd12);
        chk("R8 resume payload", payload_bad(32'h100, 12, 33), 0);

        // Ring base rewrite rewinds the index (R10); single-entry ring wraps (R3)
        wr_reg(2'd0, 32'h85); rd_reg(2'd0, d); chk("R10 base aligned", d, 32'h80);
        arm(32, 1'b1, 32'h300);
        send_frame(6, 1'b0, 90);
        chk("R10 frame at new base status", {16'h0, mem[32][31:16]}, 32'h2800);
        chk("R10 frame at new base payload", payload_bad(32'h300, 6, 90), 0);
        arm(32, 1'b1, 32'h300);
        send_frame(3, 1'b0, 44);
        chk("R3 single-entry ring wraps", {16'h0, mem[32][15:0]}, 32'd3);
        chk("R3 single-entry payload", payload_bad(32'h300, 3, 44), 0);
        chk("R4 payload before status end", ooo_cnt, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule